// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block sits between the bit-level deserializer of a serial receiver and the host side of the port. It stores up to four received bytes in arrival order and hands them to the host one at a time. Two flags tell the host whether data is waiting (`rx_rdy`) and whether every slot is taken (`rx_full`). A line-break event from the deserializer is stored in the queue as a zero byte and latches a break-change interrupt request that stays high until the host acknowledges it.

Incoming bytes use a valid/ready handshake. A byte is stored only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is combinational and is low while the receiver is disabled, while the queue is full, and in any cycle that carries a break event or a receiver-reset command. The deserializer must therefore hold its byte until it sees `in_ready`. It may also drop the byte if it has its own overrun policy.

The host side uses plain strobes. A one-cycle `rd_stb` removes the oldest byte, and that byte appears on `rd_data` from the next clock edge. `rd_data` then keeps its value until the next read that succeeds. The receiver-reset and break-acknowledge commands are also one-cycle pulses. The register decode that produces these pulses lies outside this block.

Top module: `rxq_fifo`

## Requirements
- R1: The queue holds at most four bytes. After four stored bytes, `in_ready` is low and a presented byte is not stored.
- R2: `rx_rdy` is high in the cycle after any byte or break is stored. `rx_full` is high exactly while four bytes are held.
- R3: A break event sets `brk_irq` on the next edge. `brk_irq` stays set until a `brk_clr` pulse. If a break and `brk_clr` arrive in the same cycle, the bit stays set.
- R4: A break stores the byte 0x00 in the next free slot, even when `rx_en` is low. When the queue is full and no read happens in that cycle, the 0x00 replaces the newest entry and the count stays at four.
- R5: `in_ready` equals `rx_en` AND NOT `rx_full` AND NOT `brk_evt` AND NOT `rx_reset`. As a result, a data byte never enters in the same cycle as a break.
- R6: A `rx_reset` pulse empties the queue and clears `rx_rdy` and `rx_full` on the next edge. In that cycle it overrides any read, push or break insertion. It does not change `rd_data` or `brk_irq`.
- R7: A `rd_stb` while the queue is non-empty puts the oldest byte on `rd_data` from the next edge and moves the remaining entries forward. It clears `rx_full`, and it clears `rx_rdy` when the last byte leaves.
- R8: A `rd_stb` while the queue is empty leaves `rd_data` and the fill level unchanged.
- R9: A push and a read in the same cycle leave the fill level unchanged, and arrival order is kept.
- R10: When the queue is full and a break coincides with a read, the oldest byte is read out and 0x00 is appended behind the other three bytes. No entry is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; gates `in_ready` |
| rx_reset | input | 1 | Receiver-reset command pulse; empties the queue |
| in_valid | input | 1 | Deserializer presents a byte |
| in_data | input | DATA_W | Byte from the deserializer |
| in_ready | output | 1 | Queue accepts the presented byte this cycle |
| brk_evt | input | 1 | Line-break event pulse |
| brk_clr | input | 1 | Acknowledge pulse for the break-change interrupt |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Byte returned by the latest read that succeeded |
| rx_rdy | output | 1 | At least one byte is held |
| rx_full | output | 1 | All four slots are held |
| brk_irq | output | 1 | Break-change interrupt request |

## Verification
On every cycle, the assertions check the relations between ports. `in_ready` must follow enable, fullness, break and reset. A break must leave the queue full when it was full, and must raise `brk_irq`. A reset must empty the flags. A read on an empty queue must hold `rd_data`. A push and a read together must keep the fill flags. Some behaviour can only be shown by the bench's scenarios. These cover the byte order seen by the host, the zero byte taking the newest slot rather than an older one, the zero byte being appended after a read, the zero byte being stored while the receiver is disabled, and the survival of `rd_data` across a receiver reset. The bench's scoreboard compares every read against a model queue to show them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Source of the entry written into the queue in a given cycle.
  typedef enum logic [1:0] {
    INS_NONE = 2'd0,
    INS_DATA = 2'd1,
    INS_BRK  = 2'd2
  } rxq_ins_e;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_reset,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              brk_evt,
  input  logic              rd_stb,
  output logic              in_ready,
  output logic              do_clr,
  output logic              do_pop,
  output logic              do_wr,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rx_rdy,
  output logic              rx_full
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_after_pop;
  rxq_ins_e         ins;
  logic             is_full;

  assign is_full  = (cnt_q == CNT_MAX);
  assign in_ready = rx_en && !is_full && !brk_evt && !rx_reset;
  assign do_clr   = rx_reset;
  assign do_pop   = rd_stb && (cnt_q != '0) && !rx_reset;

  // Pick what, if anything, enters the queue this cycle.
  always_comb begin
    if (rx_reset)                 ins = INS_NONE;
    else if (brk_evt)             ins = INS_BRK;
    else if (in_valid && in_ready) ins = INS_DATA;
    else                          ins = INS_NONE;
  end

  // Reads are applied before the insertion; a break into a still-full queue
  // lands on the newest slot.
  always_comb begin
    cnt_after_pop = cnt_q - {{(CNT_W-1){1'b0}}, do_pop};
    do_wr         = (ins != INS_NONE);
    wr_data       = (ins == INS_BRK) ? '0 : in_data;
    if (cnt_after_pop == CNT_MAX) begin
      wr_idx  = IDX_TOP;
      cnt_nxt = cnt_after_pop;
    end else begin
      wr_idx  = cnt_after_pop[IDX_W-1:0];
      cnt_nxt = do_wr ? cnt_after_pop + 1'b1 : cnt_after_pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (do_clr) cnt_q <= '0;
    else             cnt_q <= cnt_nxt;
  end

  assign rx_rdy  = (cnt_q != '0);
  assign rx_full = is_full;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pop,
  input  logic              wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q   [DEPTH];
  logic [DATA_W-1:0] slot_nxt [DEPTH];
  logic [DATA_W-1:0] shift_src[DEPTH];
  logic [DATA_W-1:0] rd_q;

  // Each slot takes its upper neighbour on a read; the top slot keeps itself.
  for (genvar g = 0; g < DEPTH; g++) begin : g_src
    if (g < DEPTH - 1) begin : g_mid
      assign shift_src[g] = slot_q[g+1];
    end else begin : g_top
      assign shift_src[g] = slot_q[g];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_nxt[i] = pop ? shift_src[i] : slot_q[i];
      if (wr && (wr_idx == IDX_W'(i))) slot_nxt[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (clr) begin
        for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
        slot_q <= slot_nxt;
      end
      if (pop) rd_q <= slot_q[0];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/rxq_brk.sv
module rxq_brk (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);

  logic irq_q;

  // A new break outranks a simultaneous acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (set) irq_q <= 1'b1;
    else if (clr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_reset,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              brk_evt,
  input  logic              brk_clr,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_rdy,
  output logic              rx_full,
  output logic              brk_irq
);

  logic              do_clr, do_pop, do_wr;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  rxq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_reset (rx_reset),
    .in_valid (in_valid),
    .in_data  (in_data),
    .brk_evt  (brk_evt),
    .rd_stb   (rd_stb),
    .in_ready (in_ready),
    .do_clr   (do_clr),
    .do_pop   (do_pop),
    .do_wr    (do_wr),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rx_rdy   (rx_rdy),
    .rx_full  (rx_full)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (do_clr),
    .pop     (do_pop),
    .wr      (do_wr),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  rxq_brk u_brk (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (brk_evt),
    .clr   (brk_clr),
    .irq   (brk_irq)
  );

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rx_reset,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              brk_evt,
  input logic              brk_clr,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_rdy,
  input logic              rx_full,
  input logic              brk_irq
);

  p_full_blocks_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !in_ready);

  p_full_implies_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_rdy);

  p_push_sets_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> rx_rdy);

  p_break_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_irq);

  p_irq_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_irq && !brk_clr) |=> brk_irq);

  p_break_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && brk_evt && !rx_reset) |=> rx_full);

  p_ready_gating_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (rx_en && !brk_evt && !rx_reset));

  p_reset_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!rx_rdy && !rx_full));

  p_read_clears_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rx_full && !brk_evt && !rx_reset) |=> !rx_full);

  p_empty_read_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (!rx_rdy || rx_reset)) |=> $stable(rd_data));

  p_push_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rx_rdy && in_valid && in_ready) |=> (rx_rdy && $stable(rx_full)));

endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_fifo_tb;

  localparam int DEPTH  = 4;
  localparam int DATA_W = 8;

  logic clk, rst_n;
  logic rx_en, rx_reset, in_valid, brk_evt, brk_clr, rd_stb;
  logic [DATA_W-1:0] in_data;
  logic in_ready, rx_rdy, rx_full, brk_irq;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;

  logic [DATA_W-1:0] mq[$];      // model of the queue contents
  logic [DATA_W-1:0] exp_q[$];   // scoreboard of expected read results
  string             tag_q[$];
  logic [DATA_W-1:0] last_rd = '0;
  bit                irq_m = 1'b0;

  rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_reset(rx_reset),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .brk_evt(brk_evt), .brk_clr(brk_clr), .rd_stb(rd_stb),
    .rd_data(rd_data), .rx_rdy(rx_rdy), .rx_full(rx_full), .brk_irq(brk_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; drives one cycle of stimulus, updates the model,
  // returns at the next falling edge after checking the flags.
  task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit brk,
                      input bit rd, input bit rst, input bit bclr, input string note);
    bit exp_rdy, acc;
    in_valid = v; in_data = d; brk_evt = brk; rd_stb = rd;
    rx_reset = rst; brk_clr = bclr;
    exp_rdy = rx_en && (mq.size() < DEPTH) && !brk && !rst;
    #1;
    chk(in_ready == exp_rdy, {note, " R5 in_ready"}, in_ready, exp_rdy);
    acc = v && exp_rdy;
    if (rd) begin
      if (!rst && mq.size() > 0) begin
        last_rd = mq.pop_front();
        tag_q.push_back({note, " R7 oldest byte"});
      end else begin
        tag_q.push_back({note, " R8 held value"});
      end
      exp_q.push_back(last_rd);
    end
    if (rst) mq.delete();
    else if (brk) begin
      if (mq.size() == DEPTH) mq[DEPTH-1] = '0;
      else mq.push_back('0);
    end else if (acc) mq.push_back(d);
    if (brk) irq_m = 1'b1;
    else if (bclr) irq_m = 1'b0;
    @(negedge clk);
    chk(rx_rdy == (mq.size() > 0), {note, " R2 rx_rdy"}, rx_rdy, mq.size() > 0);
    chk(rx_full == (mq.size() == DEPTH), {note, " R2 rx_full (R1 depth)"}, rx_full,
        mq.size() == DEPTH);
    chk(brk_irq == irq_m, {note, " R3 brk_irq"}, brk_irq, irq_m);
    in_valid = 0; brk_evt = 0; rd_stb = 0; rx_reset = 0; brk_clr = 0;
  endtask

  task automatic push(input logic [DATA_W-1:0] d, input string note);
    step(1, d, 0, 0, 0, 0, note);
  endtask

  task automatic read(input string note);
    step(0, 0, 0, 1, 0, 0, note);
  endtask

  // Monitor: compares each read result one edge after the strobe.
  always @(posedge clk) begin
    logic took;
    logic [DATA_W-1:0] e;
    string t;
    took = rd_stb;
    #1;
    if (took) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, {t, " rd_data"}, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; rx_en = 0; rx_reset = 0; in_valid = 0; in_data = '0;
    brk_evt = 0; brk_clr = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk(rx_rdy == 0, "R2 reset rx_rdy", rx_rdy, 0);
    chk(rx_full == 0, "R2 reset rx_full", rx_full, 0);
    chk(brk_irq == 0, "R3 reset brk_irq", brk_irq, 0);
    chk(rd_data == 0, "R8 reset rd_data", rd_data, 0);

    // R5: disabled receiver refuses data
    push(8'h11, "R5 disabled");
    rx_en = 1;

    // R1/R2: fill to four, fifth refused
    push(8'hA1, "R1"); push(8'hA2, "R1"); push(8'hA3, "R1"); push(8'hA4, "R1");
    push(8'hA5, "R1 overfill");

    // R7: reads in order, full clears
    read("R7"); read("R7");
    // R9: simultaneous push and read
    step(1, 8'hB1, 0, 1, 0, 0, "R9");
    step(1, 8'hB2, 0, 1, 0, 0, "R9");
    read("R7"); read("R7");
    // R8: read on empty holds value
    read("R8 empty"); read("R8 empty");

    // R3/R4: break on empty queue stores zero, irq held, then cleared
    push(8'hC1, "R4");
    step(0, 0, 1, 0, 0, 0, "R4 break");
    step(0, 0, 0, 0, 0, 0, "R3 hold");
    step(0, 0, 0, 0, 0, 1, "R3 clear");
    read("R4"); read("R4");

    // R4: break into full queue overwrites the newest entry
    push(8'hD1, "R4"); push(8'hD2, "R4"); push(8'hD3, "R4"); push(8'hD4, "R4");
    step(0, 0, 1, 0, 0, 0, "R4 overwrite");
    // R10: full, break and read together append the zero
    step(0, 0, 1, 1, 0, 0, "R10");
    read("R10"); read("R10"); read("R10"); read("R10");

    // R3: break and acknowledge together keep the bit
    step(0, 0, 1, 0, 0, 1, "R3 set wins");
    step(0, 0, 0, 0, 0, 1, "R3 clear");
    read("R4");

    // R4/R5: break with data in the same cycle drops the data; break while disabled
    step(1, 8'hE1, 1, 0, 0, 0, "R5 break beats data");
    rx_en = 0;
    step(0, 0, 1, 0, 0, 0, "R4 disabled break");
    rx_en = 1;
    push(8'hE2, "R4");

    // R6: receiver reset empties queue, overrides read and push, keeps rd_data and irq
    step(1, 8'hF1, 0, 1, 1, 0, "R6 reset");
    read("R6 after reset");
    push(8'hF2, "R6"); read("R6");
    step(0, 0, 0, 0, 0, 1, "R3 clear");
    step(0, 0, 0, 0, 0, 0, "idle");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule